// File: doc/BRIEF.md
# Filtered Interrupt Merger

This block sits between two per-channel active-low interrupt lines and the single interrupt line a host watches. It first brings each input into the clock domain and then filters it. A new level is accepted only after the input has held it for a set number of clock cycles. Going active (low) and going inactive (high) each have their own rejection width. The filtered lines are merged so that the combined output is active whenever either channel is active. The block has no notion of which channel is selected, so a channel is always watched.

When the host reads the control register, a read strobe freezes a two-bit picture of the filtered lines into the status output. The register read path places that picture beside its other fields. Between reads, the picture stays as it was. The rejection widths are given in system-clock cycles. With a 250 MHz clock, the defaults of 250 and 125 cycles give 1 µs and 0.5 µs. The resulting output latencies stay well inside 4 µs for assertion and 2 µs for release.

Top module: `irq_merge_filter`

## Requirements
- R1: While reset is held and right after it, `irq_n_o` is 1 and `status_o` is 2'b00. Both filtered lines start inactive.
- R2: When an input goes low and stays low for at least LOW_REJ sampling edges, `irq_n_o` falls. With SYNC_STAGES=2 it changes at the edge that lies LOW_REJ+1 edges after the first edge that samples the low level.
- R3: A low pulse on an input that covers fewer than LOW_REJ sampling edges leaves `irq_n_o` and the status unchanged. Any high sample restarts the count, so two short low pulses separated by one high cycle are also rejected.
- R4: When an active input goes high and stays high for at least HIGH_REJ edges, its filtered line is released. With no other line active, `irq_n_o` rises HIGH_REJ+1 edges after the first edge that samples the high level.
- R5: A high pulse on an active input that covers fewer than HIGH_REJ sampling edges keeps `irq_n_o` low and keeps the channel reported as active.
- R6: `irq_n_o` is low exactly when at least one filtered line is low. It stays low while the other channel is still active.
- R7: On a clock edge with `rd_strobe` high, `status_o` captures bit 0 = 1 if channel 0 is filtered active and bit 1 = 1 if channel 1 is filtered active. Without a strobe, `status_o` holds its value whatever the inputs do.
- R8: When both channels are active, both status bits read 1 (2'b11).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n_i | input | 2 | Raw active-low interrupt inputs; bit 0 is channel 0, bit 1 is channel 1 |
| rd_strobe | input | 1 | Capture the status picture on this clock edge |
| irq_n_o | output | 1 | Combined active-low interrupt |
| status_o | output | 2 | Captured pending flags; 1 means the channel is active |

## Verification
The inputs are driven with low pulses of exactly LOW_REJ and LOW_REJ-1 samples. This pins down the acceptance boundary and the exact cycle of the output edge, and it separates an off-by-one filter from a correct one. Short high glitches inside an active period, and two short low pulses split by a single high cycle, show whether the counter restarts on every bounce. Staggered activity on both channels, with one channel released at a time, separates a true merge from a single-channel path. Reads taken before and after input changes show that the status is a held picture and not a live copy.

// File: rtl/irq_merge_filter.sv
module irq_merge_filter #(
  parameter int N_CH        = 2,
  parameter int LOW_REJ     = 250,
  parameter int HIGH_REJ    = 125,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] irq_n_i,
  input  logic            rd_strobe,
  output logic            irq_n_o,
  output logic [N_CH-1:0] status_o
);

  localparam int MAXW = (LOW_REJ > HIGH_REJ) ? LOW_REJ : HIGH_REJ;
  localparam int CW   = $clog2(MAXW + 1);

  logic [N_CH-1:0] filt;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   filt_q;
    logic                   samp;
    logic [CW-1:0]          limit;

    assign samp  = sync_q[SYNC_STAGES-1];
    assign limit = filt_q ? CW'(LOW_REJ - 1) : CW'(HIGH_REJ - 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '1;
        cnt_q  <= '0;
        filt_q <= 1'b1;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], irq_n_i[g]};
        if (samp == filt_q) begin
          cnt_q <= '0;
        end else if (cnt_q == limit) begin
          filt_q <= samp;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

    assign filt[g] = filt_q;
  end

  assign irq_n_o = &filt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_o <= '0;
    else if (rd_strobe) status_o <= ~filt;
  end

endmodule

// File: rtl/irq_merge_filter_chk.sv
module irq_merge_filter_chk #(
  parameter int LOW_REJ     = 250,
  parameter int HIGH_REJ    = 125,
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] irq_n_i,
  input logic       rd_strobe,
  input logic       irq_n_o,
  input logic [1:0] status_o
);

  logic [15:0] lrun0, lrun1, hrun0, hrun1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrun0 <= '0; lrun1 <= '0; hrun0 <= '0; hrun1 <= '0;
    end else begin
      lrun0 <= irq_n_i[0]  ? 16'd0 : ((&lrun0) ? lrun0 : lrun0 + 16'd1);
      lrun1 <= irq_n_i[1]  ? 16'd0 : ((&lrun1) ? lrun1 : lrun1 + 16'd1);
      hrun0 <= !irq_n_i[0] ? 16'd0 : ((&hrun0) ? hrun0 : hrun0 + 16'd1);
      hrun1 <= !irq_n_i[1] ? 16'd0 : ((&hrun1) ? hrun1 : hrun1 + 16'd1);
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (irq_n_o && status_o == 2'b00));

  p_min_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n_o) |-> ($past(lrun0, SYNC_STAGES) >= 16'(LOW_REJ) ||
                        $past(lrun1, SYNC_STAGES) >= 16'(LOW_REJ)));

  p_min_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n_o) |-> ($past(hrun0, SYNC_STAGES) >= 16'(HIGH_REJ) &&
                        $past(hrun1, SYNC_STAGES) >= 16'(HIGH_REJ)));

  p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(status_o));

  p_status_merge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> ((|status_o) == !$past(irq_n_o)));

endmodule

bind irq_merge_filter irq_merge_filter_chk #(
  .LOW_REJ(LOW_REJ), .HIGH_REJ(HIGH_REJ), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_n_i(irq_n_i), .rd_strobe(rd_strobe),
  .irq_n_o(irq_n_o), .status_o(status_o)
);

// File: tb/irq_merge_filter_test.sv
`timescale 1ns/1ps
module irq_merge_filter_test;
  localparam int LW = 250;
  localparam int HW = 125;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] irq_n_i = 2'b11;
  logic       rd_strobe = 1'b0;
  logic       irq_n_o;
  logic [1:0] status_o;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    int         at;
    bit         is_stat;
    logic [1:0] val;
    string      tag;
  } exp_t;
  exp_t sb[$];

  irq_merge_filter #(.LOW_REJ(LW), .HIGH_REJ(HW)) uut (
    .clk(clk), .rst_n(rst_n), .irq_n_i(irq_n_i), .rd_strobe(rd_strobe),
    .irq_n_o(irq_n_o), .status_o(status_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int at, input bit is_stat, input logic [1:0] v, input string tag);
    exp_t e;
    e.at = at; e.is_stat = is_stat; e.val = v; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input logic [1:0] v, input string tag);
    push(cyc + 1, 1'b1, v, tag);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        total++;
        if (sb[i].is_stat) begin
          if (status_o !== sb[i].val) begin
            bad++;
            $display("FAIL %s cyc=%0d status actual=%b expected=%b", sb[i].tag, cyc, status_o, sb[i].val);
          end
        end else if (irq_n_o !== sb[i].val[0]) begin
          bad++;
          $display("FAIL %s cyc=%0d irq_n_o actual=%b expected=%b", sb[i].tag, cyc, irq_n_o, sb[i].val[0]);
        end
        sb.delete(i);
      end
    end
  end

  initial begin
    int c;
    idle(3);
    total++;
    if (irq_n_o !== 1'b1 || status_o !== 2'b00) begin
      bad++;
      $display("FAIL R1 reset actual=%b/%b expected=1/00", irq_n_o, status_o);
    end
    rst_n = 1'b1;
    idle(2);
    total++;
    if (irq_n_o !== 1'b1 || status_o !== 2'b00) begin
      bad++;
      $display("FAIL R1 after reset actual=%b/%b expected=1/00", irq_n_o, status_o);
    end

    // R2: accepted low on channel 0, exact edge
    c = cyc;
    push(c + LW + 1, 0, 2'b01, "R2 not yet");
    push(c + LW + 2, 0, 2'b00, "R2 fall");
    irq_n_i[0] = 1'b0;
    idle(LW + 10);
    do_read(2'b01, "R7 ch0 pending");

    // R4: release with exact edge
    c = cyc;
    push(c + HW + 1, 0, 2'b00, "R4 not yet");
    push(c + HW + 2, 0, 2'b01, "R4 rise");
    irq_n_i[0] = 1'b1;
    idle(HW + 10);
    do_read(2'b00, "R7 cleared");

    // R3: low pulse one sample short on channel 1
    c = cyc;
    push(c + LW + 1, 0, 2'b01, "R3 short low");
    push(c + LW + 2, 0, 2'b01, "R3 short low");
    push(c + LW + 5, 0, 2'b01, "R3 short low");
    irq_n_i[1] = 1'b0;
    idle(LW - 1);
    irq_n_i[1] = 1'b1;
    idle(10);
    do_read(2'b00, "R3 status untouched");

    // R2/R4 boundary: low pulse of exactly LW samples
    c = cyc;
    push(c + LW + 1, 0, 2'b01, "R2 boundary early");
    push(c + LW + 2, 0, 2'b00, "R2 boundary fall");
    push(c + LW + HW + 1, 0, 2'b00, "R4 boundary early");
    push(c + LW + HW + 2, 0, 2'b01, "R4 boundary rise");
    irq_n_i[1] = 1'b0;
    idle(LW);
    irq_n_i[1] = 1'b1;
    idle(HW + 10);

    // R5: short high glitch during an active period
    irq_n_i[0] = 1'b0;
    idle(LW + 10);
    c = cyc;
    push(c + HW + 1, 0, 2'b00, "R5 glitch");
    push(c + HW + 2, 0, 2'b00, "R5 glitch");
    push(c + HW + 6, 0, 2'b00, "R5 glitch");
    irq_n_i[0] = 1'b1;
    idle(HW - 1);
    irq_n_i[0] = 1'b0;
    idle(10);
    do_read(2'b01, "R5 still pending");
    c = cyc;
    push(c + HW + 2, 0, 2'b01, "R4 release after glitch");
    irq_n_i[0] = 1'b1;
    idle(HW + 10);

    // R3: restart on bounce
    c = cyc;
    push(c + LW + 1, 0, 2'b01, "R3 bounce");
    push(c + LW + 2, 0, 2'b01, "R3 bounce");
    push(c + 2*LW + 1, 0, 2'b01, "R3 bounce");
    push(c + 2*LW + 2, 0, 2'b01, "R3 bounce");
    push(c + 2*LW + 4, 0, 2'b01, "R3 bounce");
    irq_n_i[0] = 1'b0;
    idle(LW - 1);
    irq_n_i[0] = 1'b1;
    idle(1);
    irq_n_i[0] = 1'b0;
    idle(LW - 1);
    irq_n_i[0] = 1'b1;
    idle(10);

    // R8/R6: both active, release one at a time
    c = cyc;
    push(c + LW + 1, 0, 2'b01, "R6 early");
    push(c + LW + 2, 0, 2'b00, "R6 fall");
    irq_n_i[0] = 1'b0;
    idle(20);
    irq_n_i[1] = 1'b0;
    idle(LW + 10);
    do_read(2'b11, "R8 both pending");
    c = cyc;
    push(c + HW + 2, 0, 2'b00, "R6 other still active");
    push(c + HW + 10, 0, 2'b00, "R6 other still active");
    irq_n_i[0] = 1'b1;
    idle(HW + 20);
    do_read(2'b10, "R7 ch1 only");
    c = cyc;
    push(c + HW + 1, 0, 2'b00, "R6 last release early");
    push(c + HW + 2, 0, 2'b01, "R6 last release");
    push(c + HW + 5, 1, 2'b10, "R7 hold without read");
    irq_n_i[1] = 1'b1;
    idle(HW + 10);
    do_read(2'b00, "R7 fresh read");
    idle(5);

    if (sb.size() != 0) begin
      bad += sb.size();
      total += sb.size();
      $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule